// File: doc/BRIEF.md
# Biased floating-point stimulus generator

This block produces test operands for a floating-point exponential unit, one word per request. A word has four fields: a 2-bit exception code at the top, then a sign bit, an `EXP_W`-bit biased exponent and an `FRAC_W`-bit fraction at the bottom. An internal case index counts accepted requests. When the index is a multiple of eight, the word is a raw random pattern that covers every field, including special-value codes. Every other word is a normal number. Its exponent is confined to the narrow band where the exponential of the value neither flushes to zero nor saturates to infinity, so most of the stimulus lands where the operator does real work.

Random bits come from a 32-bit Galois LFSR. Software-free reproducibility comes from a seed load, which restarts both the LFSR and the case index. The exponent offset needs a remainder modulo `EXP_W+FRAC_W+2`. A restoring conditional-subtract reducer computes it in a fixed number of cycles, so every word takes the same latency from request to `valid`.

Top module: `fpstim_gen`

## Requirements
- R1: After reset, `valid` is low and the LFSR holds `RESET_SEED` (default 1). The case index is 0.
- R2: Each accepted request advances the LFSR exactly one step. The step is `s = (s >> 1) ^ (s[0] ? 32'h80200003 : 0)`. The word for that request is built from the stepped state `r`.
- R3: When the case index modulo 8 is 0, the word equals `r[W-1:0]`, where `W = EXP_W+FRAC_W+3`.
- R4: For any other index, word bits [W-1:W-2] are `2'b01`. Bit `EXP_W+FRAC_W` is the sign and equals `r[FRAC_W]`. Bits [FRAC_W-1:0] equal `r[FRAC_W-1:0]`.
- R5: For any other index, the exponent field [EXP_W+FRAC_W-1:FRAC_W] equals `BIAS - FRAC_W - 3 + (r[31:24] mod (EXP_W+FRAC_W+2))`, with `BIAS = 2^(EXP_W-1) - 1`. It therefore lies in [BIAS-FRAC_W-3, BIAS+EXP_W-2].
- R6: `word_idx` shows the case index of the request that produced the word. The index increments by one per accepted request and wraps at `2^IDX_W`.
- R7: `valid` is high for exactly one cycle. It rises RND_W+1 clock edges (9 by default) after the edge that accepts the request.
- R8: A request is accepted only when the generator is idle. Idle includes the cycle in which `valid` is high. `req` raised while a word is being computed is ignored and causes no extra word.
- R9: `seed_load` loads `seed_val` into the LFSR, with 0 replaced by 1, and clears the case index. It abandons any word in progress, so no `valid` follows for that word. It takes precedence over a simultaneous `req`, which is then not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Load seed, clear index, abort work |
| seed_val | input | 32 | Seed value for the LFSR |
| req | input | 1 | Request one word |
| valid | output | 1 | One-cycle pulse: `word` and `word_idx` are valid |
| word | output | EXP_W+FRAC_W+3 | Generated operand |
| word_idx | output | IDX_W | Case index of `word` |

## Verification
The hardest behaviour to reach is the remainder reducer's full range. Its input is only the top LFSR byte, so each residue of the modulus, and the largest dividends that need subtractions at every shift, appear only when the sweep draws the right states. Long runs of back-to-back requests from several seeds let the exact-value comparison reach those states. That comparison uses an arithmetic reference LFSR and a `%`-based exponent. The abort paths need a seed load to land mid-computation, and in the same cycle as a request. The bench times those cases by counting edges from the accepting edge.

// File: rtl/fpstim_pkg.sv
// Shared constants and types for the floating-point stimulus generator.
// Assumes: nothing beyond standard SystemVerilog.
package fpstim_pkg;

    // Galois feedback mask of the 32-bit maximal-length LFSR
    localparam logic [31:0] LFSR_MASK = 32'h80200003;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RED  = 2'd1,
        ST_FIN  = 2'd2
    } gen_state_t;

endpackage

// File: rtl/fpstim_lfsr.sv
// 32-bit Galois LFSR, right-shifting, with a loadable seed.
// Exposes the low OUT_W bits of the current state and the top TOP_W
// bits of the state one step ahead.
// Assumes: OUT_W <= 32, TOP_W <= 32; a zero seed is replaced by 1.
module fpstim_lfsr
    import fpstim_pkg::*;
#(
    parameter int          OUT_W      = 18,
    parameter int          TOP_W      = 8,
    parameter logic [31:0] RESET_SEED = 32'h1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      seed,
    input  logic             step,
    output logic [OUT_W-1:0] cur_low,
    output logic [TOP_W-1:0] nxt_top
);

    logic [31:0] state_q;
    logic [31:0] state_nxt;

    // One Galois step of the current state
    always_comb begin
        state_nxt = (state_q >> 1) ^ (state_q[0] ? LFSR_MASK : 32'h0);
    end

    // State register: reset, seed load (zero mapped to 1), or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_SEED;
        end else if (load) begin
            state_q <= (seed == 32'h0) ? 32'h1 : seed;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end

    assign cur_low = state_q[OUT_W-1:0];
    assign nxt_top = state_nxt[31:32-TOP_W];

endmodule

// File: rtl/fpstim_modred.sv
// Restoring remainder unit: reduces a DIN_W-bit value modulo MOD by
// conditionally subtracting MOD<<k for k = DIN_W-1 down to 0, one shift
// per cycle, so it always takes exactly DIN_W cycles after start.
// Assumes: MOD >= 1; start is not raised while busy.
module fpstim_modred #(
    parameter int DIN_W = 8,
    parameter int MOD   = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [DIN_W-1:0] din,
    output logic [DIN_W-1:0] rem,
    output logic             last
);

    localparam int MOD_W = $clog2(MOD + 1);
    localparam int SUB_W = DIN_W + MOD_W;
    localparam int CNT_W = (DIN_W > 1) ? $clog2(DIN_W) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [SUB_W-1:0] msh;
    logic             take;

    // Shifted modulus for the current step and the subtract decision
    always_comb begin
        msh  = SUB_W'(MOD) << cnt_q;
        take = ({{MOD_W{1'b0}}, rem} >= msh);
        last = busy_q && (cnt_q == '0);
    end

    // Remainder, step counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            rem    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            rem    <= din;
            cnt_q  <= CNT_W'(DIN_W - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (take) begin
                rem <= rem - msh[DIN_W-1:0];
            end
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpstim_pack.sv
// Combinational word builder. Either passes the raw random bits
// through, or forms a normal number with exception code 01, the random
// sign and fraction, and exponent BIAS-FRAC_W-3+rem.
// Assumes: rem < EXP_W+FRAC_W+2 and the resulting exponent fits EXP_W.
module fpstim_pack #(
    parameter int EXP_W  = 6,
    parameter int FRAC_W = 9,
    parameter int REM_W  = 8
) (
    input  logic                      raw_sel,
    input  logic [EXP_W+FRAC_W+2:0]   rnd,
    input  logic [REM_W-1:0]          rem,
    output logic [EXP_W+FRAC_W+2:0]   word
);

    localparam int W      = EXP_W + FRAC_W + 3;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_LO = BIAS - FRAC_W - 3;

    logic [EXP_W-1:0] expo;

    // Select raw or constrained format
    always_comb begin
        expo = EXP_W'(EXP_LO) + EXP_W'(rem);
        if (raw_sel) begin
            word = rnd;
        end else begin
            word = {2'b01, rnd[FRAC_W], expo, rnd[FRAC_W-1:0]};
        end
    end

    // W is used for documentation of the word width
    logic [W-1:0] unused_w;
    assign unused_w = word;

endmodule

// File: rtl/fpstim_gen.sv
// Top of the biased floating-point stimulus generator. On each accepted
// request it steps the LFSR, reduces the top random byte modulo
// EXP_W+FRAC_W+2, and presents one word with a one-cycle valid pulse.
// Assumes: IDX_W >= 3, EXP_W+FRAC_W+3 <= 32, FRAC_W+1 <= 32-RND_W,
// and BIAS > FRAC_W+3 so constrained exponents stay normal.
module fpstim_gen
    import fpstim_pkg::*;
#(
    parameter int          EXP_W      = 6,
    parameter int          FRAC_W     = 9,
    parameter int          IDX_W      = 8,
    parameter int          RND_W      = 8,
    parameter logic [31:0] RESET_SEED = 32'h1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     seed_load,
    input  logic [31:0]              seed_val,
    input  logic                     req,
    output logic                     valid,
    output logic [EXP_W+FRAC_W+2:0]  word,
    output logic [IDX_W-1:0]         word_idx
);

    localparam int W   = EXP_W + FRAC_W + 3;
    localparam int MOD = EXP_W + FRAC_W + 2;

    gen_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic             red_last;
    logic [W-1:0]     rnd_low;
    logic [RND_W-1:0] rnd_top;
    logic [RND_W-1:0] rem;
    logic [W-1:0]     packed_w;

    assign accept = (state_q == ST_IDLE) && req && !seed_load;

    fpstim_lfsr #(
        .OUT_W      (W),
        .TOP_W      (RND_W),
        .RESET_SEED (RESET_SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load),
        .seed    (seed_val),
        .step    (accept),
        .cur_low (rnd_low),
        .nxt_top (rnd_top)
    );

    fpstim_modred #(
        .DIN_W (RND_W),
        .MOD   (MOD)
    ) u_red (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (seed_load),
        .start (accept),
        .din   (rnd_top),
        .rem   (rem),
        .last  (red_last)
    );

    fpstim_pack #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .REM_W  (RND_W)
    ) u_pack (
        .raw_sel (word_idx[2:0] == 3'd0),
        .rnd     (rnd_low),
        .rem     (rem),
        .word    (packed_w)
    );

    // Controller: accept, wait for the reducer, publish the word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            word_idx <= '0;
            word     <= '0;
            valid    <= 1'b0;
        end else if (seed_load) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        word_idx <= idx_q;
                        idx_q    <= idx_q + 1'b1;
                        state_q  <= ST_RED;
                    end
                end
                ST_RED: begin
                    if (red_last) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    word    <= packed_w;
                    valid   <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fpstim_chk.sv
// Property checker for fpstim_gen, attached with bind below.
// Assumes: field slices are connected from the top's output word.
module fpstim_chk #(
    parameter int EXP_W  = 6,
    parameter int FRAC_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seed_load,
    input logic             valid,
    input logic [1:0]       exc_code,
    input logic [EXP_W-1:0] exp_fld,
    input logic [2:0]       idx_lo
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int E_LO = BIAS - FRAC_W - 3;
    localparam int E_HI = BIAS + EXP_W - 2;

    // R7: valid is a single-cycle pulse
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R4: constrained words carry the normal exception code
    assert_exc_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && idx_lo != 3'd0) |-> (exc_code == 2'b01));

    // R5: constrained exponents stay in the useful band
    assert_exp_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && idx_lo != 3'd0) |->
            (int'(exp_fld) >= E_LO && int'(exp_fld) <= E_HI));

    // R9: a seed load never produces a word on the next cycle
    assert_seed_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !valid);

endmodule

bind fpstim_gen fpstim_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .valid     (valid),
    .exc_code  (word[EXP_W+FRAC_W+2:EXP_W+FRAC_W+1]),
    .exp_fld   (word[EXP_W+FRAC_W-1:FRAC_W]),
    .idx_lo    (word_idx[2:0])
);

// File: tb/sim_fpstim_gen.sv
`timescale 1ns/1ps
module sim_fpstim_gen;

    localparam int EXP_W  = 6;
    localparam int FRAC_W = 9;
    localparam int IDX_W  = 8;
    localparam int RND_W  = 8;
    localparam int W      = EXP_W + FRAC_W + 3;
    localparam int MODV   = EXP_W + FRAC_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seed_load = 1'b0;
    logic [31:0]   seed_val = 32'h0;
    logic          req = 1'b0;
    logic          valid;
    logic [W-1:0]  word;
    logic [IDX_W-1:0] word_idx;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_lfsr;
    int          m_idx;

    always #5 clk = ~clk;

    fpstim_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .req       (req),
        .valid     (valid),
        .word      (word),
        .word_idx  (word_idx)
    );

    function automatic logic [31:0] ref_step(logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
    endfunction

    function automatic logic [W-1:0] ref_word(logic [31:0] r, int idx);
        int e;
        if (idx % 8 == 0) return r[W-1:0];
        e = BIAS - FRAC_W - 3 + (int'(r[31:24]) % MODV);
        return {2'b01, r[FRAC_W], e[EXP_W-1:0], r[FRAC_W-1:0]};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request, return the word and the edge count to valid
    task automatic do_req(output logic [W-1:0] w, output int idx, output int lat);
        @(negedge clk) req = 1'b1;
        @(posedge clk);
        @(negedge clk) req = 1'b0;
        lat = 1;
        while (!valid && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        lat = lat - 1;
        w = word;
        idx = int'(word_idx);
    endtask

    // Request and compare against the reference model
    task automatic req_and_check(input bit chk_lat);
        logic [W-1:0] w, ew;
        int idx, lat, e;
        do_req(w, idx, lat);
        m_lfsr = ref_step(m_lfsr);
        ew = ref_word(m_lfsr, m_idx);
        if (m_idx % 8 == 0)
            check(w == ew, "R3 raw word", 64'(w), 64'(ew));
        else begin
            check(w == ew, "R2 R4 R5 constrained word", 64'(w), 64'(ew));
            check(w[W-1:W-2] == 2'b01, "R4 exception code", 64'(w[W-1:W-2]), 64'h1);
            e = int'(w[EXP_W+FRAC_W-1:FRAC_W]);
            check(e >= BIAS-FRAC_W-3 && e <= BIAS+EXP_W-2, "R5 exponent band",
                  64'(e), 64'(BIAS));
        end
        check(idx == m_idx, "R6 case index", 64'(idx), 64'(m_idx));
        if (chk_lat)
            check(lat == RND_W + 1, "R7 latency", 64'(lat), 64'(RND_W + 1));
        m_idx = (m_idx + 1) % (1 << IDX_W);
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk) begin seed_load = 1'b1; seed_val = s; end
        @(negedge clk) seed_load = 1'b0;
        m_lfsr = (s == 32'h0) ? 32'h1 : s;
        m_idx = 0;
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (valid) seen++;
        end
        check(seen == 0, tag, 64'(seen), 64'h0);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_lfsr = 32'h1;
        m_idx = 0;
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R1 valid low in reset", 64'(valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid == 1'b0, "R1 valid low after reset", 64'(valid), 64'h0);

        // R1 R2 R3: sweep from the reset seed, through an index wrap (R6)
        for (int i = 0; i < 300; i++) req_and_check(i < 12);

        // R8: req during computation is ignored
        begin
            logic [W-1:0] w, ew;
            @(negedge clk) req = 1'b1;
            @(posedge clk);
            @(negedge clk) req = 1'b0;
            repeat (3) @(negedge clk);
            req = 1'b1;
            @(negedge clk) req = 1'b0;
            while (!valid) @(negedge clk);
            w = word;
            m_lfsr = ref_step(m_lfsr);
            ew = ref_word(m_lfsr, m_idx);
            check(w == ew, "R8 word with ignored req", 64'(w), 64'(ew));
            m_idx = (m_idx + 1) % (1 << IDX_W);
            expect_quiet(15, "R8 no extra word");
            req_and_check(1'b1);
        end

        // R9: seed load abandons work in progress
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        repeat (3) @(negedge clk);
        load_seed(32'hC0FFEE11);
        expect_quiet(15, "R9 aborted word");
        for (int i = 0; i < 20; i++) req_and_check(1'b0);

        // R9: reload reproduces the sequence from index 0
        load_seed(32'hC0FFEE11);
        for (int i = 0; i < 20; i++) req_and_check(1'b0);

        // R9: seed load beats a simultaneous request
        @(negedge clk) begin seed_load = 1'b1; seed_val = 32'h1234ABCD; req = 1'b1; end
        @(negedge clk) begin seed_load = 1'b0; req = 1'b0; end
        m_lfsr = 32'h1234ABCD;
        m_idx = 0;
        expect_quiet(15, "R9 request dropped on load");
        for (int i = 0; i < 10; i++) req_and_check(1'b0);

        // R9: zero seed maps to 1
        load_seed(32'h0);
        for (int i = 0; i < 10; i++) req_and_check(1'b0);

        // Further seeds to spread reducer residues (R5)
        load_seed(32'hFFFFFFFF);
        for (int i = 0; i < 200; i++) req_and_check(1'b0);
        load_seed(32'h8000_0000);
        for (int i = 0; i < 200; i++) req_and_check(1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule